// File: doc/BRIEF.md
# Byte-Pointer Expansion Memory Mapper

This block sits on the cartridge side of an 8-bit console CPU bus. It holds a 16-bit byte pointer split into a low and a high 8-bit register. Software points it at any byte of a large expansion ROM or expansion RAM, then reaches that byte through a small fixed window in CPU space. Each expansion memory byte is its own bank, so a pointer update followed by one access reaches any byte. The upper nibble of the high register also selects an 8K bank of CHR RAM.

The decode window is open only while the ROM-select input is high (CPU A15 low), A12 is high and M2 is high. A13 and A14 take no part in the decode, so the window repeats at several places in CPU space. Address bits A4 and A5 mark a cycle as a pointer load. A11 together with A2 selects expansion ROM or expansion RAM. Pointer loads ignore R/W, so a read cycle loads whatever byte is on the data bus. A single address can load one or both pointer registers and also select expansion memory.

The model runs on a fast system clock and samples M2. Each pointer register takes the bus byte held during the M2-high phase. The new value takes effect on the first system clock edge at which M2 is seen low.

Top module: `xmem_mapper`

## Requirements
- R1: After reset both pointer registers are zero, so `xram_addr_o` reads 0x0000, `xrom_addr_o[15:0]` reads 0x0000 and `chr_bank_o` reads 0.
- R2: The decode window is open exactly when `romsel_n_i`=1, `addr_i[12]`=1 and `m2_i`=1. A13 and A14 do not affect it. While the window is closed, both chip selects are high and no pointer register loads.
- R3: A window cycle with `addr_i[4]`=1 loads the low pointer with the `data_i` byte seen during M2 high. The new value appears on the outputs after the first clock edge that samples M2 low.
- R4: A window cycle with `addr_i[5]`=1 loads the high pointer the same way. When bits 4 and 5 are both 1, both registers take the same byte.
- R5: `rw_i` has no effect on pointer loads. A read cycle in the window with bit 4 or 5 set loads the byte driven onto the bus by the selected memory.
- R6: `xrom_cs_no` is 0 exactly when the window is open, `addr_i[11]`=1 and `addr_i[2]`=0. `xrom_addr_o` is {`addr_i[0]`, high, low}, with bit 16 taken from A0.
- R7: `xram_cs_no` is 0 exactly when the window is open, `addr_i[11]`=1 and `addr_i[2]`=1. `xram_addr_o` is {high, low}. While RAM is selected `xram_rw_o` follows `rw_i`; otherwise it is 1 (read).
- R8: The two chip selects are never low at the same time.
- R9: `chr_bank_o` equals bits 7:4 of the high pointer.
- R10: During a cycle that both selects expansion memory and loads a pointer, the expansion addresses keep showing the old pointer until the load takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than M2 |
| rst_ni | input | 1 | Asynchronous reset, active low |
| romsel_n_i | input | 1 | ROM-select strobe, high when CPU A15 is low |
| m2_i | input | 1 | CPU M2 phase signal |
| addr_i | input | 15 | CPU address A14..A0 |
| rw_i | input | 1 | CPU R/W, 1 = read |
| data_i | input | 8 | CPU data bus as seen by the cartridge |
| xrom_addr_o | output | 17 | Expansion ROM byte address |
| xrom_cs_no | output | 1 | Expansion ROM chip select, active low |
| xram_addr_o | output | 16 | Expansion RAM byte address |
| xram_cs_no | output | 1 | Expansion RAM chip select, active low |
| xram_rw_o | output | 1 | Expansion RAM R/W |
| chr_bank_o | output | 4 | CHR RAM bank number |

## Verification
The hardest case to reach is a read of expansion ROM whose address also sets A4 or A5. On that cycle the byte loaded into the pointer is the ROM content at the old pointer, so the loaded value depends on memory data that the bench itself must supply. The bench models the ROM as a function of its address and drives that byte onto `data_i` whenever it expects ROM to be selected. Random addresses are biased toward the open window and toward A11, so these self-referencing loads happen often. Directed cycles cover the dual-register load, mirrored A13/A14 values and closed-window cycles.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  // bit positions the decode depends on
  localparam int unsigned BIT_ROMHI = 0;
  localparam int unsigned BIT_MEMSEL = 2;
  localparam int unsigned BIT_LOLD = 4;
  localparam int unsigned BIT_HILD = 5;
  localparam int unsigned BIT_XMEM = 11;
  localparam int unsigned BIT_WIN = 12;

  typedef struct packed {
    logic ld_lo;
    logic ld_hi;
    logic rom_sel;
    logic ram_sel;
  } dec_t;
endpackage

// File: rtl/xmem_decode.sv
module xmem_decode
  import xmem_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              romsel_n_i,
  input  logic              m2_i,
  output dec_t              dec_o
);
  logic win;
  logic xmem;

  assign win  = romsel_n_i & addr_i[BIT_WIN] & m2_i;
  assign xmem = win & addr_i[BIT_XMEM];

  always_comb begin
    dec_o.ld_lo   = win & addr_i[BIT_LOLD];
    dec_o.ld_hi   = win & addr_i[BIT_HILD];
    dec_o.rom_sel = xmem & ~addr_i[BIT_MEMSEL];
    dec_o.ram_sel = xmem & addr_i[BIT_MEMSEL];
  end
endmodule

// File: rtl/xmem_ptr_regs.sv
module xmem_ptr_regs
  import xmem_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              m2_i,
  input  logic              romsel_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] lo_o,
  output logic [DATA_W-1:0] hi_o
);
  logic              m2_q;
  logic              romsel_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] data_s;
  logic              m2_fall;
  dec_t              dec_s;

  // bus snapshot tracks the bus while M2 is high, frozen when it drops
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m2_q     <= 1'b0;
      romsel_s <= 1'b0;
      addr_s   <= '0;
      data_s   <= '0;
    end else begin
      m2_q <= m2_i;
      if (m2_i) begin
        romsel_s <= romsel_n_i;
        addr_s   <= addr_i;
        data_s   <= data_i;
      end
    end
  end

  assign m2_fall = m2_q & ~m2_i;

  xmem_decode #(.ADDR_W(ADDR_W)) u_dec_s (
    .addr_i    (addr_s),
    .romsel_n_i(romsel_s),
    .m2_i      (1'b1),
    .dec_o     (dec_s)
  );

  // latch closure emulated at M2 fall
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_o <= '0;
      hi_o <= '0;
    end else if (m2_fall) begin
      if (dec_s.ld_lo) lo_o <= data_s;
      if (dec_s.ld_hi) hi_o <= data_s;
    end
  end

  logic unused_dec;
  assign unused_dec = dec_s.rom_sel ^ dec_s.ram_sel;
endmodule

// File: rtl/xmem_mapper.sv
module xmem_mapper
  import xmem_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CHR_W  = 4,
  localparam int unsigned PTR_W  = 2 * DATA_W,
  localparam int unsigned XROM_W = PTR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              romsel_n_i,
  input  logic              m2_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rw_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [XROM_W-1:0] xrom_addr_o,
  output logic              xrom_cs_no,
  output logic [PTR_W-1:0]  xram_addr_o,
  output logic              xram_cs_no,
  output logic              xram_rw_o,
  output logic [CHR_W-1:0]  chr_bank_o
);
  dec_t              dec_live;
  logic [DATA_W-1:0] ptr_lo;
  logic [DATA_W-1:0] ptr_hi;

  xmem_decode #(.ADDR_W(ADDR_W)) u_dec_live (
    .addr_i    (addr_i),
    .romsel_n_i(romsel_n_i),
    .m2_i      (m2_i),
    .dec_o     (dec_live)
  );

  xmem_ptr_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .m2_i      (m2_i),
    .romsel_n_i(romsel_n_i),
    .addr_i    (addr_i),
    .data_i    (data_i),
    .lo_o      (ptr_lo),
    .hi_o      (ptr_hi)
  );

  assign xrom_addr_o = {addr_i[BIT_ROMHI], ptr_hi, ptr_lo};
  assign xram_addr_o = {ptr_hi, ptr_lo};
  assign xrom_cs_no  = ~dec_live.rom_sel;
  assign xram_cs_no  = ~dec_live.ram_sel;
  assign xram_rw_o   = dec_live.ram_sel ? rw_i : 1'b1;
  assign chr_bank_o  = ptr_hi[DATA_W-1 -: CHR_W];

  logic unused_ld;
  assign unused_ld = dec_live.ld_lo ^ dec_live.ld_hi;
endmodule

// File: rtl/xmem_mapper_chk.sv
module xmem_mapper_chk #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned PTR_W  = 16,
  parameter int unsigned CHR_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              romsel_n_i,
  input logic              m2_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rw_i,
  input logic              xrom_cs_no,
  input logic              xram_cs_no,
  input logic              xram_rw_o,
  input logic [PTR_W-1:0]  xram_addr_o,
  input logic [PTR_W:0]    xrom_addr_o,
  input logic [CHR_W-1:0]  chr_bank_o
);
  // R8
  cs_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xram_cs_no | xrom_cs_no);

  // R2
  closed_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(romsel_n_i && addr_i[12] && m2_i) |-> (xrom_cs_no && xram_cs_no));

  // R6
  rom_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xrom_cs_no |-> (addr_i[11] && !addr_i[2] && xrom_addr_o[PTR_W] == addr_i[0]));

  // R7
  ram_rw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xram_cs_no |-> (addr_i[11] && addr_i[2] && xram_rw_o == rw_i));

  // R9
  chr_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chr_bank_o == xram_addr_o[PTR_W-1 -: CHR_W]);

  // R3
  ptr_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(xram_addr_o) |-> (!$past(m2_i) && $past(m2_i, 2)));

  // R10
  ptr_hold_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(m2_i) && m2_i) |-> $stable(xram_addr_o));
endmodule

bind xmem_mapper xmem_mapper_chk #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .CHR_W(CHR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .romsel_n_i (romsel_n_i),
  .m2_i       (m2_i),
  .addr_i     (addr_i),
  .rw_i       (rw_i),
  .xrom_cs_no (xrom_cs_no),
  .xram_cs_no (xram_cs_no),
  .xram_rw_o  (xram_rw_o),
  .xram_addr_o(xram_addr_o),
  .xrom_addr_o(xrom_addr_o),
  .chr_bank_o (chr_bank_o)
);

// File: tb/tb_xmem_mapper.sv
module tb_xmem_mapper;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        romsel_n_i = 1'b0;
  logic        m2_i = 1'b0;
  logic [14:0] addr_i = '0;
  logic        rw_i = 1'b1;
  logic [7:0]  data_i = '0;
  logic [16:0] xrom_addr_o;
  logic        xrom_cs_no;
  logic [15:0] xram_addr_o;
  logic        xram_cs_no;
  logic        xram_rw_o;
  logic [3:0]  chr_bank_o;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] m_lo = '0;
  logic [7:0] m_hi = '0;

  xmem_mapper dut (.*);

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  function automatic logic [7:0] rom_byte(input logic [16:0] a);
    return a[7:0] ^ a[15:8] ^ {7'd0, a[16]} ^ 8'h5a;
  endfunction

  function automatic logic exp_win(input logic rs, input logic [14:0] a);
    return rs & a[12];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // one M2 cycle; ROM reads get data from the ROM model
  task automatic bus_cycle(input logic rs, input logic [14:0] a, input logic rw, input logic [7:0] d);
    logic w, rsel, msel;
    logic [7:0] drv;
    w    = exp_win(rs, a);
    rsel = w & a[11] & ~a[2];
    msel = w & a[11] & a[2];
    drv  = (rsel && rw) ? rom_byte({a[0], m_hi, m_lo}) : d;
    @(negedge clk_i);
    romsel_n_i = rs; addr_i = a; rw_i = rw; data_i = drv; m2_i = 1'b0;
    @(negedge clk_i);
    check("R2 rom cs m2 low", xrom_cs_no, 1'b1);
    check("R2 ram cs m2 low", xram_cs_no, 1'b1);
    m2_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    check("R6 rom cs", xrom_cs_no, !rsel);
    check("R7 ram cs", xram_cs_no, !msel);
    check("R7 ram rw", xram_rw_o, msel ? rw : 1'b1);
    check("R10 rom addr old ptr", xrom_addr_o, {a[0], m_hi, m_lo});
    m2_i = 1'b0;
    if (w && a[4]) m_lo = drv;
    if (w && a[5]) m_hi = drv;
    @(negedge clk_i);
    check("R3/R4/R5 ptr", xram_addr_o, {m_hi, m_lo});
    check("R9 chr", chr_bank_o, m_hi[7:4]);
  endtask

  initial begin
    int seed;
    seed = 32'h1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk_i);
    check("R1 ram addr", xram_addr_o, 16'h0);
    check("R1 rom addr", xrom_addr_o[15:0], 16'h0);
    check("R1 chr", chr_bank_o, 4'h0);
    rst_ni = 1'b1;
    // R4 dual load, write
    bus_cycle(1'b1, 15'h1030, 1'b0, 8'hc7);
    // R2 mirror via A13/A14
    bus_cycle(1'b1, 15'h7010, 1'b0, 8'h3e);
    // R2 closed window: romsel low, A12 low
    bus_cycle(1'b0, 15'h1030, 1'b0, 8'h11);
    bus_cycle(1'b1, 15'h0030, 1'b0, 8'h22);
    // R5 read loads, R6 rom with A0=1 and A4 set
    bus_cycle(1'b1, 15'h1811, 1'b1, 8'h00);
    // R7 ram write and read with A5 set
    bus_cycle(1'b1, 15'h1824, 1'b0, 8'h9b);
    bus_cycle(1'b1, 15'h1804, 1'b1, 8'h40);
    for (int i = 0; i < 400; i++) begin
      logic [14:0] a;
      a = 15'($urandom);
      if ($urandom % 4 != 0) a[12] = 1'b1;
      if ($urandom % 2 != 0) a[11] = 1'b1;
      bus_cycle(($urandom % 5) != 0, a, 1'($urandom), 8'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule